// File: doc/BRIEF.md
# Protected Serial Configuration Register

This block is a single write-protected settings register that sits behind a two-wire serial slave. It does not handle bit timing. A bus front end hands it decoded events: a start, a received byte, a stop, and a request for a byte to transmit. For each received byte the block returns an acknowledge decision. For each read request it returns the register contents.

The register holds five persistent settings: two power-up timing bits, two watchdog bits and one block-protect bit. It also holds two volatile enable latches. Software must set the write-enable latch and then the register-write-enable latch, each with its own write transaction, before a third write can change the persistent bits. A change takes effect only when a stop ends a write that delivered exactly one accepted data byte. After a persistent update, a busy window models the nonvolatile store. During that window the device-select byte is refused.

Top module: `cfgreg_prot`

## Requirements
- R1: Reset clears both enable latches and leaves the persistent bits unchanged. Before the first update, the persistent bits hold the INIT_PERSIST value, ordered {PUP1, WD1, WD0, BP, PUP0}. Reset also forgets the address pointer.
- R2: The device-select byte is acknowledged only when bits 7:4 equal 1011b and the block is not busy. Bit 1 carries address bit 8 and bit 0 selects read (1) or write (0). On a mismatch the byte is refused, and every byte up to the next start is refused.
- R3: After an acknowledged write select, the next byte is acknowledged and taken as address bits 7:0. The first data byte is acknowledged only when the full 9-bit address equals 1FFh. Otherwise it is refused.
- R4: Once one data byte has been accepted, every further data byte in the same transaction is refused. The first byte is still committed at the stop.
- R5: A data byte commits only when a stop ends its transaction. If a repeated start arrives first, the byte has no effect.
- R6: A committed data byte of 02h sets the write-enable latch (WEL).
- R7: A committed 06h sets the register-write-enable latch (RWEL) only when WEL is already set. Otherwise it is ignored.
- R8: When both latches are set, a committed byte loads the persistent bits from data bits 7, 6, 5, 4 and 0 (PUP1, WD1, WD0, BP, PUP0) and clears both latches.
- R9: While RWEL is clear, a committed byte with bits 2:1 equal to 00b clears both latches. Any other byte apart from the R6 and R7 commands is ignored.
- R10: After a persistent update, the device-select byte is refused for BUSY_CYCLES clock cycles.
- R11: A read select is acknowledged only when the stored address pointer is 1FFh. A read then returns one byte laid out from bit 7 to bit 0 as PUP1, WD1, WD0, BP, 0, RWEL, WEL, PUP0. A second read request in the same transaction returns nothing.
- R12: Each received byte produces exactly one acknowledge-valid pulse, one cycle after the byte event. Read data is valid one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_start_i | input | 1 | Start or repeated start seen |
| bus_byte_vld_i | input | 1 | A byte was received |
| bus_byte_i | input | 8 | Received byte |
| bus_stop_i | input | 1 | Stop seen |
| bus_rd_req_i | input | 1 | Front end needs a byte to transmit |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_ok_o | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Register contents for transmit |

## Verification
The bench first steps through the full enable sequence and checks the acknowledge and read-back at each stage. A design that dropped the WEL precondition would let a lone 06h open the register. A design that committed on the byte itself instead of at the stop would take a write that was abandoned by a repeated start.

The bench checks that a second data byte is refused. A design that kept latching data would let a trailing byte overwrite the committed value.

The bench checks that a select arriving right after an update is refused. It also checks that a reset drops the latches but keeps the settings. A design that reset the persistent bits would read back the initial value instead of the last stored one.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

   localparam int PERSIST_W = 5;

   // data patterns that drive the enable latch pair
   localparam logic [7:0] CMD_ARM_WEL  = 8'h02;
   localparam logic [7:0] CMD_ARM_RWEL = 8'h06;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_ADDR,
      ST_DATA,
      ST_HOLD,
      ST_RD,
      ST_SKIP
   } bus_st_e;

   typedef struct packed {
      logic pup1;
      logic wd1;
      logic wd0;
      logic bp;
      logic pup0;
   } persist_t;

   // register image: PUP1 WD1 WD0 BP 0 RWEL WEL PUP0
   function automatic logic [7:0] reg_image(persist_t p, logic rwel, logic wel);
      return {p.pup1, p.wd1, p.wd0, p.bp, 1'b0, rwel, wel, p.pup0};
   endfunction

   function automatic persist_t take_persist(logic [7:0] d);
      persist_t p;
      p.pup1 = d[7];
      p.wd1  = d[6];
      p.wd0  = d[5];
      p.bp   = d[4];
      p.pup0 = d[0];
      return p;
   endfunction

endpackage

// File: rtl/cfgreg_busy_timer.sv
module cfgreg_busy_timer #(
   parameter int CYCLES = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);

   generate
      if (CYCLES == 0) begin : g_none
         assign busy_o = 1'b0;
      end else begin : g_count
         localparam int CNT_W = $clog2(CYCLES + 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load_i) begin
               cnt_q <= CNT_W'(CYCLES);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end

         assign busy_o = (cnt_q != '0);

         assert_busy_after_commit_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> busy_o);
      end
   endgenerate

endmodule

// File: rtl/cfgreg_ctrl_bits.sv
module cfgreg_ctrl_bits
   import cfgreg_pkg::*;
#(
   parameter logic [PERSIST_W-1:0] INIT_PERSIST = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 commit_i,
   input  logic [7:0]           data_i,
   output logic [PERSIST_W-1:0] persist_o,
   output logic                 wel_o,
   output logic                 rwel_o,
   output logic                 arm_busy_o
);

   logic wel_q, rwel_q;
   // persistent contents survive reset; the initializer stands for stored data
   persist_t persist_q = persist_t'(INIT_PERSIST);
   logic store_now;

   assign store_now = commit_i && wel_q && rwel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q  <= 1'b0;
         rwel_q <= 1'b0;
      end else if (commit_i) begin
         if (wel_q && rwel_q) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
         end else if (data_i[2:1] == 2'b00) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
         end else if (data_i == CMD_ARM_WEL) begin
            wel_q <= 1'b1;
         end else if (data_i == CMD_ARM_RWEL && wel_q) begin
            rwel_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (store_now) begin
         persist_q <= take_persist(data_i);
      end
   end

   assign persist_o  = persist_q;
   assign wel_o      = wel_q;
   assign rwel_o     = rwel_q;
   assign arm_busy_o = store_now;

   assert_rwel_needs_wel_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      rwel_q |-> wel_q);

   assert_persist_only_on_store_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !store_now |=> $stable(persist_q));

endmodule

// File: rtl/cfgreg_bus_fsm.sv
module cfgreg_bus_fsm
   import cfgreg_pkg::*;
#(
   parameter int                    PREAMBLE_W = 4,
   parameter logic [PREAMBLE_W-1:0] PREAMBLE   = 4'b1011,
   parameter int                    ADDR_W     = 9,
   parameter logic [ADDR_W-1:0]     REG_ADDR   = 9'h1FF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start_i,
   input  logic       ev_byte_i,
   input  logic [7:0] byte_i,
   input  logic       ev_stop_i,
   input  logic       ev_rd_i,
   input  logic       busy_i,
   input  logic [7:0] reg_byte_i,
   output logic       ack_vld_o,
   output logic       ack_ok_o,
   output logic       rd_vld_o,
   output logic [7:0] rd_data_o,
   output logic       commit_o,
   output logic [7:0] commit_data_o
);

   localparam int HI_W = ADDR_W - 8;

   bus_st_e           state_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              ptr_vld_q;
   logic [HI_W-1:0]   hi_q;
   logic [7:0]        pend_q;
   logic              pre_match;
   logic              ptr_hit;

   assign pre_match = (byte_i[7 -: PREAMBLE_W] == PREAMBLE);
   assign ptr_hit   = ptr_vld_q && (ptr_q == REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ptr_q     <= '0;
         ptr_vld_q <= 1'b0;
         hi_q      <= '0;
         pend_q    <= '0;
         ack_vld_o <= 1'b0;
         ack_ok_o  <= 1'b0;
         rd_vld_o  <= 1'b0;
         rd_data_o <= '0;
         commit_o  <= 1'b0;
      end else begin
         ack_vld_o <= 1'b0;
         ack_ok_o  <= 1'b0;
         rd_vld_o  <= 1'b0;
         commit_o  <= 1'b0;
         if (ev_start_i) begin
            state_q <= ST_SEL;
         end else if (ev_stop_i) begin
            commit_o <= (state_q == ST_HOLD);
            state_q  <= ST_IDLE;
         end else if (ev_byte_i) begin
            ack_vld_o <= 1'b1;
            case (state_q)
               ST_SEL: begin
                  if (pre_match && !busy_i) begin
                     if (byte_i[0]) begin
                        if (ptr_hit) begin
                           ack_ok_o <= 1'b1;
                           state_q  <= ST_RD;
                        end else begin
                           state_q <= ST_SKIP;
                        end
                     end else begin
                        ack_ok_o <= 1'b1;
                        hi_q     <= byte_i[HI_W:1];
                        state_q  <= ST_ADDR;
                     end
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
               ST_ADDR: begin
                  ack_ok_o  <= 1'b1;
                  ptr_q     <= {hi_q, byte_i};
                  ptr_vld_q <= 1'b1;
                  state_q   <= ST_DATA;
               end
               ST_DATA: begin
                  if (ptr_hit) begin
                     ack_ok_o <= 1'b1;
                     pend_q   <= byte_i;
                     state_q  <= ST_HOLD;
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
               default: begin
                  // hold, read, skip and idle refuse every byte
               end
            endcase
         end else if (ev_rd_i && state_q == ST_RD) begin
            rd_vld_o  <= 1'b1;
            rd_data_o <= reg_byte_i;
            state_q   <= ST_SKIP;
         end
      end
   end

   assign commit_data_o = pend_q;

   assert_ack_follows_byte_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      ev_byte_i |=> ack_vld_o);

   assert_ack_has_cause_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld_o |-> $past(ev_byte_i));

   assert_busy_blocks_select_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_byte_i && !ev_start_i && !ev_stop_i && state_q == ST_SEL && busy_i) |=> !ack_ok_o);

   assert_extra_byte_nack_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_byte_i && !ev_start_i && !ev_stop_i && state_q == ST_HOLD) |=> !ack_ok_o);

endmodule

// File: rtl/cfgreg_prot.sv
module cfgreg_prot
   import cfgreg_pkg::*;
#(
   parameter int                    PREAMBLE_W   = 4,
   parameter logic [PREAMBLE_W-1:0] PREAMBLE     = 4'b1011,
   parameter int                    ADDR_W       = 9,
   parameter logic [ADDR_W-1:0]     REG_ADDR     = 9'h1FF,
   parameter int                    BUSY_CYCLES  = 500,
   parameter logic [PERSIST_W-1:0]  INIT_PERSIST = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_start_i,
   input  logic       bus_byte_vld_i,
   input  logic [7:0] bus_byte_i,
   input  logic       bus_stop_i,
   input  logic       bus_rd_req_i,
   output logic       ack_vld_o,
   output logic       ack_ok_o,
   output logic       rd_vld_o,
   output logic [7:0] rd_data_o
);

   // select byte: preamble on top, address high bits below it, R/W in bit 0
   initial begin
      assert (ADDR_W > 8 && PREAMBLE_W >= 1 && PREAMBLE_W + (ADDR_W - 8) + 1 <= 8)
         else $error("cfgreg_prot: preamble and address bits do not fit the select byte");
      assert (BUSY_CYCLES >= 0)
         else $error("cfgreg_prot: BUSY_CYCLES must not be negative");
   end

   logic                 busy;
   logic                 commit;
   logic [7:0]           commit_data;
   logic [PERSIST_W-1:0] persist;
   logic                 wel, rwel, arm_busy;
   logic [7:0]           reg_byte;

   assign reg_byte = reg_image(persist_t'(persist), rwel, wel);

   cfgreg_bus_fsm #(
      .PREAMBLE_W (PREAMBLE_W),
      .PREAMBLE   (PREAMBLE),
      .ADDR_W     (ADDR_W),
      .REG_ADDR   (REG_ADDR)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .ev_start_i    (bus_start_i),
      .ev_byte_i     (bus_byte_vld_i),
      .byte_i        (bus_byte_i),
      .ev_stop_i     (bus_stop_i),
      .ev_rd_i       (bus_rd_req_i),
      .busy_i        (busy),
      .reg_byte_i    (reg_byte),
      .ack_vld_o     (ack_vld_o),
      .ack_ok_o      (ack_ok_o),
      .rd_vld_o      (rd_vld_o),
      .rd_data_o     (rd_data_o),
      .commit_o      (commit),
      .commit_data_o (commit_data)
   );

   cfgreg_ctrl_bits #(
      .INIT_PERSIST (INIT_PERSIST)
   ) u_bits (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .data_i     (commit_data),
      .persist_o  (persist),
      .wel_o      (wel),
      .rwel_o     (rwel),
      .arm_busy_o (arm_busy)
   );

   cfgreg_busy_timer #(
      .CYCLES (BUSY_CYCLES)
   ) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (arm_busy),
      .busy_o (busy)
   );

   assert_one_event_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_start_i, bus_byte_vld_i, bus_stop_i, bus_rd_req_i}));

   assert_read_zero_bit_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld_o |-> (rd_data_o[3] == 1'b0));

endmodule

// File: tb/cfgreg_prot_tb.sv
`timescale 1ns/1ps
module cfgreg_prot_tb;

   localparam logic [1:0] K_START = 2'd0;
   localparam logic [1:0] K_BYTE  = 2'd1;
   localparam logic [1:0] K_STOP  = 2'd2;
   localparam logic [1:0] K_RD    = 2'd3;
   localparam int NV = 43;

   // {req[3:0], kind[1:0], data[7:0], expect[7:0]}
   localparam logic [21:0] VEC [NV] = '{
      // R2 R3 R11 R1: dummy write of address 1FFh, then random read of reset value
      {4'd11, K_START, 8'h00, 8'h00},
      {4'd2,  K_BYTE,  8'hB2, 8'h01},
      {4'd3,  K_BYTE,  8'hFF, 8'h01},
      {4'd11, K_START, 8'h00, 8'h00},
      {4'd11, K_BYTE,  8'hB3, 8'h01},
      {4'd1,  K_RD,    8'h00, 8'hA0},
      {4'd11, K_STOP,  8'h00, 8'h00},
      // R2: wrong preamble, rest of transaction refused
      {4'd2,  K_START, 8'h00, 8'h00},
      {4'd2,  K_BYTE,  8'h72, 8'h00},
      {4'd2,  K_BYTE,  8'h02, 8'h00},
      {4'd2,  K_STOP,  8'h00, 8'h00},
      // R3: address 0FFh is not the register
      {4'd3,  K_START, 8'h00, 8'h00},
      {4'd3,  K_BYTE,  8'hB0, 8'h01},
      {4'd3,  K_BYTE,  8'hFF, 8'h01},
      {4'd3,  K_BYTE,  8'h02, 8'h00},
      {4'd3,  K_STOP,  8'h00, 8'h00},
      // R4 R6: 02h accepted, trailing byte refused
      {4'd4,  K_START, 8'h00, 8'h00},
      {4'd4,  K_BYTE,  8'hB2, 8'h01},
      {4'd4,  K_BYTE,  8'hFF, 8'h01},
      {4'd4,  K_BYTE,  8'h02, 8'h01},
      {4'd4,  K_BYTE,  8'h06, 8'h00},
      {4'd4,  K_STOP,  8'h00, 8'h00},
      {4'd6,  K_START, 8'h00, 8'h00},
      {4'd6,  K_BYTE,  8'hB3, 8'h01},
      {4'd6,  K_RD,    8'h00, 8'hA2},
      {4'd6,  K_STOP,  8'h00, 8'h00},
      // R7: 06h with WEL set
      {4'd7,  K_START, 8'h00, 8'h00},
      {4'd7,  K_BYTE,  8'hB2, 8'h01},
      {4'd7,  K_BYTE,  8'hFF, 8'h01},
      {4'd7,  K_BYTE,  8'h06, 8'h01},
      {4'd7,  K_STOP,  8'h00, 8'h00},
      {4'd7,  K_START, 8'h00, 8'h00},
      {4'd7,  K_BYTE,  8'hB3, 8'h01},
      {4'd7,  K_RD,    8'h00, 8'hA6},
      {4'd7,  K_STOP,  8'h00, 8'h00},
      // R8: persistent update with 5Dh
      {4'd8,  K_START, 8'h00, 8'h00},
      {4'd8,  K_BYTE,  8'hB2, 8'h01},
      {4'd8,  K_BYTE,  8'hFF, 8'h01},
      {4'd8,  K_BYTE,  8'h5D, 8'h01},
      {4'd8,  K_STOP,  8'h00, 8'h00},
      // R10: select right after the update is refused
      {4'd10, K_START, 8'h00, 8'h00},
      {4'd10, K_BYTE,  8'hB3, 8'h00},
      {4'd10, K_STOP,  8'h00, 8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       st = 1'b0, bv = 1'b0, sp = 1'b0, rr = 1'b0;
   logic [7:0] bd = '0;
   logic       ack_vld, ack_ok, rd_vld;
   logic [7:0] rd_data;

   logic       s_av, s_ak, s_rv;
   logic [7:0] s_rd;
   int         n_cmp = 0;
   int         n_bad = 0;

   always #5 clk = ~clk;

   cfgreg_prot #(
      .BUSY_CYCLES  (20),
      .INIT_PERSIST (5'b10100)
   ) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_start_i    (st),
      .bus_byte_vld_i (bv),
      .bus_byte_i     (bd),
      .bus_stop_i     (sp),
      .bus_rd_req_i   (rr),
      .ack_vld_o      (ack_vld),
      .ack_ok_o       (ack_ok),
      .rd_vld_o       (rd_vld),
      .rd_data_o      (rd_data)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %02h expected %02h", req, what, got, exp);
      end
   endtask

   // one event for one cycle; outputs sampled at the following falling edge
   task automatic ev(input logic [1:0] k, input logic [7:0] d);
      @(negedge clk);
      st = (k == K_START);
      bv = (k == K_BYTE);
      sp = (k == K_STOP);
      rr = (k == K_RD);
      bd = d;
      @(negedge clk);
      st = 1'b0; bv = 1'b0; sp = 1'b0; rr = 1'b0;
      s_av = ack_vld; s_ak = ack_ok; s_rv = rd_vld; s_rd = rd_data;
   endtask

   task automatic byte_chk(input int req, input logic [7:0] d, input logic exp_ok);
      ev(K_BYTE, d);
      chk(req, {6'b0, s_av, s_ak}, {6'b0, 1'b1, exp_ok}, "ack");
   endtask

   task automatic rd_chk(input int req, input logic [7:0] exp);
      ev(K_RD, 8'h00);
      chk(req, {7'b0, s_rv}, 8'h01, "read valid");
      chk(req, s_rd, exp, "read data");
   endtask

   task automatic write_reg(input int req, input logic [7:0] d);
      ev(K_START, 8'h00);
      byte_chk(req, 8'hB2, 1'b1);
      byte_chk(req, 8'hFF, 1'b1);
      byte_chk(req, d, 1'b1);
      ev(K_STOP, 8'h00);
   endtask

   task automatic read_reg(input int req, input logic [7:0] exp);
      ev(K_START, 8'h00);
      byte_chk(req, 8'hB2, 1'b1);
      byte_chk(req, 8'hFF, 1'b1);
      ev(K_START, 8'h00);
      byte_chk(req, 8'hB3, 1'b1);
      rd_chk(req, exp);
      ev(K_STOP, 8'h00);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL R12 watchdog: actual hung expected finished run");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs idle in reset
      chk(1, {5'b0, ack_vld, ack_ok, rd_vld}, 8'h00, "reset outputs");
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         ev(VEC[i][17:16], VEC[i][15:8]);
         if (VEC[i][17:16] == K_BYTE) begin
            chk(int'(VEC[i][21:18]), {6'b0, s_av, s_ak}, {6'b0, 1'b1, VEC[i][0]}, "table ack");
         end else if (VEC[i][17:16] == K_RD) begin
            chk(int'(VEC[i][21:18]), {7'b0, s_rv}, 8'h01, "table read valid");
            chk(int'(VEC[i][21:18]), s_rd, VEC[i][7:0], "table read data");
         end
      end

      // R12: no acknowledge pulse without a byte
      @(negedge clk);
      chk(12, {7'b0, ack_vld}, 8'h00, "idle ack");

      // R10 R8: after the busy window, reading shows 5Dh stored, latches clear
      repeat (25) @(negedge clk);
      read_reg(8, 8'h51);

      // R5: data followed by repeated start is dropped
      ev(K_START, 8'h00);
      byte_chk(5, 8'hB2, 1'b1);
      byte_chk(5, 8'hFF, 1'b1);
      byte_chk(5, 8'h02, 1'b1);
      ev(K_START, 8'h00);
      byte_chk(5, 8'hB3, 1'b1);
      rd_chk(5, 8'h51);
      ev(K_STOP, 8'h00);

      // R7: 06h without WEL is ignored
      write_reg(7, 8'h06);
      read_reg(7, 8'h51);

      // R9: clear pattern and ignored pattern
      write_reg(6, 8'h02);
      read_reg(6, 8'h53);
      write_reg(9, 8'h08);
      read_reg(9, 8'h51);
      write_reg(9, 8'h02);
      write_reg(9, 8'h5F);
      read_reg(9, 8'h53);
      write_reg(9, 8'h00);
      read_reg(9, 8'h51);

      // R11: only one byte per read transaction
      ev(K_START, 8'h00);
      byte_chk(11, 8'hB2, 1'b1);
      byte_chk(11, 8'hFF, 1'b1);
      ev(K_START, 8'h00);
      byte_chk(11, 8'hB3, 1'b1);
      rd_chk(11, 8'h51);
      ev(K_RD, 8'h00);
      chk(11, {7'b0, s_rv}, 8'h00, "second read");
      ev(K_STOP, 8'h00);

      // R1: reset drops latches and pointer, keeps settings
      write_reg(1, 8'h02);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      ev(K_START, 8'h00);
      byte_chk(11, 8'hB3, 1'b0);
      ev(K_STOP, 8'h00);
      read_reg(1, 8'h51);

      summary();
      $finish;
   end

endmodule